// File: doc/BRIEF.md
# AGC Serial Word Transmitter

This block sends a 12-bit automatic gain control value to an external receiver over three wires: a continuously running serial clock, an active-low frame marker and a data line. The serial clock comes from the system clock through a divider whose half-period is set at run time. Each frame has sixteen bit slots. Four zero padding bits come first, then the gain word with its most significant bit leading. The receiver drops the first four bits.

The gain computation raises a one-cycle strobe together with a new word. The block holds the word until the next frame can begin. A word that arrives while a frame is on the wire does not disturb that frame. It goes out in the next frame, and if several words arrive during one frame, the newest one wins. Frame marker and data change only in the system cycle in which the serial clock rises. The receiver therefore samples on the falling edge, half a serial period after each change.

Top module: `agc_serial_tx`

## Requirements
- R1: While reset is held and just after it, sclk is 0, frame_n is 1 and sdata is 0.
- R2: sclk stays high for H system cycles and low for H system cycles, where H is half_period, and a half_period of 0 is treated as 1.
- R3: While frame_n is 0, sclk has exactly 16 falling edges, so one frame spans 16 serial clock periods.
- R4: Counted from the first falling sclk edge of a frame, the first 4 samples are 0 and samples 5 to 16 are agc_word bits 11 down to 0, in that order.
- R5: frame_n and sdata change only in the system cycle in which sclk goes from 0 to 1.
- R6: After a strobe on agc_load while no frame is in progress, frame_n falls within 2*H+2 system cycles.
- R7: A word loaded during a frame leaves that frame unchanged. The next frame carries it and starts one serial period (2*H system cycles with frame_n high) after the current frame ends.
- R8: When several words are loaded during one frame, only the last of them is sent in the next frame.
- R9: A frame starts only when a word has been loaded since the previous frame began. With no new load, frame_n stays 1.
- R10: sdata is 0 whenever frame_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | DIV_W (8) | System cycles per sclk half-period; 0 acts as 1 |
| agc_word | input | DATA_W (12) | Gain word to transmit |
| agc_load | input | 1 | One-cycle strobe that captures agc_word |
| sclk | output | 1 | Free-running serial clock |
| frame_n | output | 1 | Low while a frame's 16 bit slots are on the wire |
| sdata | output | 1 | Serial data, padding first, then the word MSB first |

## Verification
The bench models a falling-edge receiver. It feeds the block random words at several divider settings: 0, 1 and small odd and even values. The divider settings separate a correct half-period count from off-by-one counts and from a missing zero clamp. Directed words of all ones, a single low bit and a single high bit expose bit-order reversal and padding that is not zeroed. Single and double loads in mid-frame separate correct holding of the latest word from corruption of the frame in flight and from first-word-wins behaviour. Quiet gaps with no load expose frames that start without a new word.

// File: rtl/agc_tx_pkg.sv
package agc_tx_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } tx_state_e;
endpackage

// File: rtl/agc_sclk_gen.sv
module agc_sclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_period,
   output logic             sclk,
   output logic             rise_evt
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;
   logic             wrap;

   // a zero setting would stall the clock, so it is clamped to one cycle
   assign lim  = (half_period == '0) ? DIV_W'(1) : half_period;
   assign wrap = (cnt >= lim - DIV_W'(1));
   assign rise_evt = wrap && !sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         sclk <= ~sclk;
      end else begin
         cnt  <= cnt + DIV_W'(1);
      end
   end

   // R2
   rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt |=> !rise_evt)
      else $error("sclk rose on two consecutive cycles");
endmodule

// File: rtl/agc_word_hold.sv
module agc_word_hold #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word_in,
   input  logic              take,
   output logic              pend,
   output logic [DATA_W-1:0] held
);
   // a new load wins over a take in the same cycle, so the newest word stays queued
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         held <= '0;
      end else if (load) begin
         pend <= 1'b1;
         held <= word_in;
      end else if (take) begin
         pend <= 1'b0;
      end
   end
endmodule

// File: rtl/agc_frame_shifter.sv
module agc_frame_shifter
   import agc_tx_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int PAD_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_evt,
   input  logic              pend,
   input  logic [DATA_W-1:0] held,
   output logic              take,
   output logic              sdata,
   output logic              frame_n
);
   localparam int FRAME_W = PAD_W + DATA_W;
   localparam int SLOT_W  = $clog2(FRAME_W);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_W - 1);

   tx_state_e          state;
   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] frame_vec;
   logic [SLOT_W-1:0]  slot;

   // word in the low bits, zero padding above it so it leaves first
   for (genvar i = 0; i < FRAME_W; i++) begin : g_vec
      if (i < DATA_W) begin : g_dat
         assign frame_vec[i] = held[i];
      end else begin : g_pad
         assign frame_vec[i] = 1'b0;
      end
   end

   assign take    = rise_evt && (state == ST_IDLE) && pend;
   assign sdata   = shreg[FRAME_W-1];
   assign frame_n = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         shreg <= '0;
         slot  <= '0;
      end else if (rise_evt) begin
         if (state == ST_IDLE) begin
            if (pend) begin
               state <= ST_SEND;
               shreg <= frame_vec;
               slot  <= '0;
            end
         end else if (slot == LAST) begin
            state <= ST_IDLE;
            shreg <= '0;
            slot  <= '0;
         end else begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            slot  <= slot + SLOT_W'(1);
         end
      end
   end

   // R3
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND && rise_evt && slot == LAST) |=> frame_n)
      else $error("frame ran past its last slot");

   // R7
   hold_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND && !rise_evt) |=> $stable(shreg))
      else $error("frame contents moved between sclk rises");
endmodule

// File: rtl/agc_serial_tx.sv
module agc_serial_tx #(
   parameter int DATA_W = 12,
   parameter int PAD_W  = 4,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  half_period,
   input  logic [DATA_W-1:0] agc_word,
   input  logic              agc_load,
   output logic              sclk,
   output logic              frame_n,
   output logic              sdata
);
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (PAD_W < 0) begin : g_bad_pad
      $error("PAD_W must not be negative");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic              rise_evt;
   logic              take;
   logic              pend;
   logic [DATA_W-1:0] held;

   agc_sclk_gen #(.DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .half_period(half_period),
      .sclk(sclk), .rise_evt(rise_evt));

   agc_word_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(agc_load), .word_in(agc_word),
      .take(take), .pend(pend), .held(held));

   agc_frame_shifter #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .pend(pend),
      .held(held), .take(take), .sdata(sdata), .frame_n(frame_n));

   // R5
   edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_n != $past(frame_n) || sdata != $past(sdata)) |-> (sclk && !$past(sclk)))
      else $error("frame or data moved away from an sclk rise");

   // R10
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_n |-> !sdata)
      else $error("data line active outside a frame");
endmodule

// File: tb/sim_agc_serial_tx.sv
module sim_agc_serial_tx;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  half_period = 8'd2;
   logic [11:0] agc_word = '0;
   logic        agc_load = 1'b0;
   logic        sclk, frame_n, sdata;

   agc_serial_tx u0 (
      .clk(clk), .rst_n(rst_n), .half_period(half_period),
      .agc_word(agc_word), .agc_load(agc_load),
      .sclk(sclk), .frame_n(frame_n), .sdata(sdata));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int eff_h(logic [7:0] h);
      return (h == 0) ? 1 : int'(h);
   endfunction

   // receiver model state
   bit          mon_on = 0;
   logic        ps, pf, psd;
   int          h_eff = 2, run = 0, skip = 2, bitcnt = 0, hi_run = 0, frames_done = 0;
   logic [15:0] rx;
   logic [11:0] exp_w, next_exp;
   bit          has_next = 0, chk_latency = 0, expect_b2b = 0;
   int          load_cyc = 0;

   always @(negedge clk) if (mon_on) begin
      // R2 half-period length
      if (sclk == ps) run++;
      else begin
         if (skip > 0) skip--;
         else chk(run == h_eff, "R2 sclk half period", run, h_eff);
         run = 1;
      end
      // R5 transitions only with sclk rise
      if (frame_n != pf || sdata != psd)
         chk(sclk && !ps, "R5 change away from sclk rise", {ps, sclk}, 2'b01);
      // R10 idle data low
      if (frame_n) chk(!sdata, "R10 sdata while idle", sdata, 0);
      if (ps && !sclk && !frame_n) begin
         rx = {rx[14:0], sdata};
         bitcnt++;
      end
      if (pf && !frame_n) begin
         chk(has_next, "R9 frame without update", 0, 1);
         exp_w = next_exp;
         has_next = 0;
         bitcnt = 0;
         rx = '0;
         if (chk_latency) begin
            chk(cyc - load_cyc <= 2*h_eff + 2, "R6 start latency", cyc - load_cyc, 2*h_eff + 2);
            chk_latency = 0;
         end
         if (expect_b2b) begin
            chk(hi_run == 2*h_eff, "R7 gap before queued frame", hi_run, 2*h_eff);
            expect_b2b = 0;
         end
      end
      if (!pf && frame_n) begin
         chk(bitcnt == 16, "R3 slots per frame", bitcnt, 16);
         chk(rx[15:12] == 4'h0, "R4 padding bits", rx[15:12], 0);
         chk(rx[11:0] == exp_w, "R4 R8 word bits", rx[11:0], exp_w);
         frames_done++;
         hi_run = 1;
      end else if (frame_n) hi_run++;
      ps = sclk; pf = frame_n; psd = sdata;
   end

   task automatic load(logic [11:0] w, bit idle);
      @(posedge clk); #1;
      agc_word = w; agc_load = 1'b1;
      next_exp = w; has_next = 1;
      if (idle) begin chk_latency = 1; load_cyc = cyc; end
      @(posedge clk); #1;
      agc_load = 1'b0;
   endtask

   task automatic wait_start();
      int n = 0;
      while (frame_n && n < 4000) begin @(negedge clk); n++; end
      if (frame_n) chk(0, "R6 frame never started", 1, 0);
   endtask

   task automatic wait_done();
      int target = frames_done + 1;
      int n = 0;
      while (frames_done < target && n < 8000) begin @(negedge clk); n++; end
      if (frames_done < target) chk(0, "R3 frame never ended", frames_done, target);
   endtask

   task automatic set_h(logic [7:0] h);
      @(posedge clk); #1;
      half_period = h; h_eff = eff_h(h); skip = 2;
   endtask

   task automatic idle_check();
      repeat (4*h_eff + 6) @(posedge clk);
      #1;
      // R9 no update, no frame
      chk(frame_n == 1'b1, "R9 frame_n stays high", frame_n, 1);
      chk(sdata == 1'b0, "R10 idle sdata", sdata, 0);
   endtask

   // one transfer; mid = number of loads made while the frame is on the wire
   task automatic transfer(logic [11:0] w, int mid, logic [11:0] m1, logic [11:0] m2);
      load(w, 1);
      wait_start();
      if (mid > 0) begin
         repeat (1 + $urandom % (4*h_eff)) @(posedge clk);
         load(m1, 0);
         if (mid > 1) begin
            repeat (1 + $urandom % (4*h_eff)) @(posedge clk);
            load(m2, 0);
         end
         expect_b2b = 1;
         wait_done();   // R7 first frame unchanged
         wait_done();   // R8 queued frame carries last load
      end else begin
         wait_done();
      end
      idle_check();
   endtask

   initial begin
      int wd = 0;
      forever begin
         @(posedge clk); wd++;
         if (wd > 150000) begin
            chk(0, "watchdog expired", wd, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
      chk(frame_n == 1'b1, "R1 reset frame_n", frame_n, 1);
      chk(sdata == 1'b0, "R1 reset sdata", sdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sclk == 1'b0 && frame_n == 1'b1 && sdata == 1'b0, "R1 after reset",
          {sclk, frame_n, sdata}, 3'b010);
      ps = sclk; pf = frame_n; psd = sdata; run = 0; skip = 2;
      mon_on = 1;
      idle_check();

      // directed corners
      set_h(8'd0);  transfer(12'hFFF, 0, '0, '0);          // R2 clamp
      set_h(8'd1);  transfer(12'h001, 0, '0, '0);          // R4 LSB last
      set_h(8'd3);  transfer(12'h800, 2, 12'hA5A, 12'h5A5); // R7 R8
      set_h(8'd2);  transfer(12'h7FE, 1, 12'h3C3, '0);      // R7

      // constrained random
      for (int i = 0; i < 40; i++) begin
         int sel = $urandom % 5;
         logic [7:0] hv = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd1 :
                          (sel == 2) ? 8'd2 : (sel == 3) ? 8'd3 : 8'd6;
         set_h(hv);
         transfer(12'($urandom), $urandom % 3, 12'($urandom), 12'($urandom));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule